// File: doc/BRIEF.md
# Two-Strike Hard Overcurrent Guard

This block is the second line of overcurrent defence in a switching converter controller. A comparator outside the block raises a flag whenever the switch current passes a hard limit. That limit sits above the normal cycle-by-cycle current limit: about 0.6 A against 0.4 A. A single excursion can come from a disturbance. A short on the output produces one excursion in every switching cycle. The block therefore waits for trips in two consecutive switching cycles before it acts.

The comparator flag is ignored while the gate is off and for a fixed blanking interval after each turn-on. The default interval is 30 clocks, which is 300 ns at 100 MHz. At most one trip counts in each switching cycle. The first counted trip moves the block into a warning state. If the following cycle has no trip, the block returns to idle. A trip in that following cycle turns the switch off and latches the shutdown.

The latch has no timer and no clear pin. It stays set until the supply falls below its turn-off level. The start-up sequencer then recharges the supply at reduced current and restarts, so a short that persists produces hiccup operation. The sequencer learns of the shutdown through a one-clock fault request.

Top module: `hard_trip_guard`

## Requirements
- R1: After a synchronous reset, `sw_kill` and `fault_req` are 0 and the guard is idle. A reset also clears a latched shutdown.
- R2: `oc_trip` is ignored while `gate_on` is 0, and during the first BLANK_CYC rising clock edges at which `gate_on` is 1 (edge indices 0 to BLANK_CYC-1, counted from the first edge that sees the gate on). It is also ignored in any clock in which `cycle_start` is 1. From edge index BLANK_CYC on, a 1 on `oc_trip` counts as a trip.
- R3: At most one trip counts in each switching cycle. A switching cycle runs from one `cycle_start` pulse to the next, so two trips within one cycle never latch.
- R4: A trip counted from idle moves the guard to warning and leaves `sw_kill` at 0.
- R5: If a counted trip occurs in the cycle right after the cycle that entered warning, `sw_kill` rises at the clock edge that samples that trip. It then stays 1 while `vdd_low` stays 0. Over any sequence of cycles, the guard latches if and only if two adjacent cycles both hold a counted trip.
- R6: If the cycle after the warning cycle ends without a trip, the guard returns to idle at the next `cycle_start`. A trip after that only re-enters warning.
- R7: A 1 on `vdd_low` returns the guard to idle at that clock edge. It clears a latched `sw_kill` and any warning. Trips are ignored while `vdd_low` is 1.
- R8: `fault_req` is a single-clock pulse. It is raised at the same edge where `sw_kill` rises, exactly once for each latch event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on | input | 1 | Power switch gate is driven on |
| cycle_start | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_trip | input | 1 | Hard overcurrent comparator output |
| vdd_low | input | 1 | Supply is below the turn-off threshold |
| sw_kill | output | 1 | Registered; holds the switch off while latched |
| fault_req | output | 1 | Registered one-clock fault request to the start-up sequencer |

## Verification
The assertions assume that `cycle_start` arrives while the comparator window is closed, at gate turn-on or while the gate is off. They also assume that `gate_on` stays high for more than BLANK_CYC clocks when a trip is meant to be evaluated. The stimulus raises `cycle_start` only on the first clock of each on-time and keeps each on-time at 40 clocks against a blanking interval of 30. Trips are placed by edge index, so the blanking boundary is swept one position at a time. All sixteen trip patterns over four cycles are compared with a pairwise-adjacency rule.

// File: rtl/hg_pkg.sv
package hg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WARN  = 2'd1,
    ST_LATCH = 2'd2
  } guard_st_t;
endpackage

// File: rtl/hg_blank_timer.sv
module hg_blank_timer #(
  parameter int BLANK_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  output logic window
);
  localparam int CW = $clog2(BLANK_CYC + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  // Counts on-time edges, saturating at the blanking length
  always_ff @(posedge clk) begin
    if (rst || !gate_on)
      cnt_q <= '0;
    else if (cnt_q != LIMIT)
      cnt_q <= cnt_q + 1'b1;
  end

  assign window = gate_on && (cnt_q == LIMIT);

  generate
    if (BLANK_CYC > 0) begin : g_chk
      AST_WIN_AFTER_ON: assert property (@(posedge clk) disable iff (rst)
        window |-> $past(gate_on)); // R2
      AST_NO_WIN_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> !window); // R2
    end
  endgenerate
endmodule

// File: rtl/hg_cycle_capture.sv
module hg_cycle_capture (
  input  logic clk,
  input  logic rst,
  input  logic window,
  input  logic cycle_start,
  input  logic oc_trip,
  input  logic vdd_low,
  output logic trip_pulse
);
  logic hit_q;

  // One counted trip per switching cycle
  assign trip_pulse = window && oc_trip && !hit_q && !cycle_start && !vdd_low;

  always_ff @(posedge clk) begin
    if (rst || cycle_start)
      hit_q <= 1'b0;
    else if (trip_pulse)
      hit_q <= 1'b1;
  end

  AST_ONE_TRIP_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trip_pulse |=> !trip_pulse); // R3
endmodule

// File: rtl/hg_strike_fsm.sv
module hg_strike_fsm
  import hg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  input  logic trip_pulse,
  input  logic vdd_low,
  output logic sw_kill,
  output logic fault_req
);
  guard_st_t state_q, state_d;
  logic      fresh_q, fresh_d;

  always_comb begin
    state_d = state_q;
    fresh_d = fresh_q;
    if (vdd_low) begin
      state_d = ST_IDLE;
      fresh_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (trip_pulse) begin
            state_d = ST_WARN;
            fresh_d = 1'b1;
          end
        end
        ST_WARN: begin
          if (trip_pulse) begin
            state_d = ST_LATCH;
            fresh_d = 1'b0;
          end else if (cycle_start) begin
            if (fresh_q)
              fresh_d = 1'b0;
            else
              state_d = ST_IDLE;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fresh_q   <= 1'b0;
      sw_kill   <= 1'b0;
      fault_req <= 1'b0;
    end else begin
      state_q   <= state_d;
      fresh_q   <= fresh_d;
      sw_kill   <= (state_d == ST_LATCH);
      fault_req <= (state_d == ST_LATCH) && (state_q != ST_LATCH);
    end
  end

  AST_FIRST_TRIP_NO_KILL: assert property (@(posedge clk) disable iff (rst)
    (trip_pulse && state_q == ST_IDLE && !vdd_low) |=> !sw_kill); // R4
  AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sw_kill && !vdd_low) |=> sw_kill); // R5
  AST_UV_RELEASE: assert property (@(posedge clk) disable iff (rst)
    vdd_low |=> (!sw_kill && !fault_req)); // R7
  AST_REQ_WITH_KILL: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_kill) |-> fault_req); // R8
  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    fault_req |=> !fault_req); // R8
endmodule

// File: rtl/hard_trip_guard.sv
module hard_trip_guard #(
  parameter int BLANK_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  input  logic cycle_start,
  input  logic oc_trip,
  input  logic vdd_low,
  output logic sw_kill,
  output logic fault_req
);
  logic window;
  logic trip_pulse;

  hg_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .gate_on (gate_on),
    .window  (window)
  );

  hg_cycle_capture u_capture (
    .clk         (clk),
    .rst         (rst),
    .window      (window),
    .cycle_start (cycle_start),
    .oc_trip     (oc_trip),
    .vdd_low     (vdd_low),
    .trip_pulse  (trip_pulse)
  );

  hg_strike_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cycle_start (cycle_start),
    .trip_pulse  (trip_pulse),
    .vdd_low     (vdd_low),
    .sw_kill     (sw_kill),
    .fault_req   (fault_req)
  );
endmodule

// File: tb/sim_hard_trip_guard.sv
module sim_hard_trip_guard;
  localparam int BLANK = 30;
  localparam int ON_LEN = 40;
  localparam int OFF_LEN = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_on = 1'b0;
  logic cycle_start = 1'b0;
  logic oc_trip = 1'b0;
  logic vdd_low = 1'b0;
  logic sw_kill, fault_req;

  int checks = 0;
  int errors = 0;
  int fr_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hard_trip_guard #(.BLANK_CYC(BLANK)) u0 (
    .clk(clk), .rst(rst), .gate_on(gate_on), .cycle_start(cycle_start),
    .oc_trip(oc_trip), .vdd_low(vdd_low), .sw_kill(sw_kill), .fault_req(fault_req)
  );

  always @(negedge clk) if (fault_req) fr_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gate_on = 1'b0; cycle_start = 1'b0; oc_trip = 1'b0; vdd_low = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fr_cnt = 0;
  endtask

  // One switching cycle; trips at on-time edge indices p1/p2 (-1 = none)
  task automatic run_cycle(input int p1, input int p2, input bit off_trip);
    for (int k = 0; k < ON_LEN; k++) begin
      @(negedge clk);
      gate_on = 1'b1;
      cycle_start = (k == 0);
      oc_trip = (k == p1) || (k == p2);
    end
    for (int k = 0; k < OFF_LEN; k++) begin
      @(negedge clk);
      gate_on = 1'b0;
      cycle_start = 1'b0;
      oc_trip = off_trip;
    end
    @(negedge clk);
    oc_trip = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 kill after reset", sw_kill, 0);
    chk("R1 fault_req after reset", fault_req, 0);

    // R2: sweep trip position across the blanking boundary
    for (int j = 0; j < ON_LEN; j++) begin
      do_reset();
      run_cycle(j, -1, 1'b0);
      run_cycle(j, -1, 1'b0);
      chk($sformatf("R2 blank sweep pos %0d kill", j), sw_kill, (j >= BLANK) ? 1 : 0);
      chk($sformatf("R8 blank sweep pos %0d fault pulses", j), fr_cnt, (j >= BLANK) ? 1 : 0);
    end

    // R2: trips while gate is off
    do_reset();
    run_cycle(-1, -1, 1'b1);
    run_cycle(-1, -1, 1'b1);
    run_cycle(-1, -1, 1'b1);
    chk("R2 gate-off trips ignored", sw_kill, 0);

    // R3: two trips in one cycle
    do_reset();
    run_cycle(BLANK + 1, BLANK + 5, 1'b0);
    chk("R3 double trip one cycle", sw_kill, 0);
    run_cycle(-1, -1, 1'b0);
    run_cycle(BLANK + 2, -1, 1'b0);
    chk("R3 no carry of extra trip", sw_kill, 0);

    // R4 / R5 / R6: every 4-cycle trip pattern
    for (int p = 0; p < 16; p++) begin
      int exp_l;
      exp_l = ((p & (p >> 1)) != 0) ? 1 : 0;
      do_reset();
      for (int c = 0; c < 4; c++)
        run_cycle(((p >> c) & 1) ? BLANK + 3 : -1, -1, 1'b0);
      if (exp_l != 0) begin
        chk($sformatf("R5 pattern %0d kill", p), sw_kill, 1);
        chk($sformatf("R8 pattern %0d pulses", p), fr_cnt, 1);
      end else begin
        chk($sformatf("R6 pattern %0d kill", p), sw_kill, 0);
        chk($sformatf("R4 pattern %0d pulses", p), fr_cnt, 0);
      end
    end

    // R4: one trip alone
    do_reset();
    run_cycle(BLANK, -1, 1'b0);
    chk("R4 single trip no kill", sw_kill, 0);

    // R5: kill rises at the edge sampling the second trip, then holds
    do_reset();
    run_cycle(BLANK + 4, -1, 1'b0);
    for (int k = 0; k < ON_LEN; k++) begin
      @(negedge clk);
      if (k == BLANK + 4) chk("R5 kill before second trip edge", sw_kill, 0);
      if (k == BLANK + 5) chk("R5 kill right after second trip edge", sw_kill, 1);
      if (k == BLANK + 5) chk("R8 fault_req same edge", fault_req, 1);
      if (k == BLANK + 6) chk("R8 fault_req one clock", fault_req, 0);
      gate_on = 1'b1;
      cycle_start = (k == 0);
      oc_trip = (k == BLANK + 4);
    end
    @(negedge clk);
    gate_on = 1'b0; oc_trip = 1'b0;
    run_cycle(-1, -1, 1'b0);
    run_cycle(-1, -1, 1'b0);
    chk("R5 kill holds", sw_kill, 1);
    chk("R8 one pulse per latch", fr_cnt, 1);

    // R7: undervoltage clears latch
    vdd_low = 1'b1;
    @(negedge clk);
    chk("R7 uv clears kill", sw_kill, 0);
    run_cycle(BLANK + 1, -1, 1'b0);
    run_cycle(BLANK + 1, -1, 1'b0);
    chk("R7 trips ignored under uv", sw_kill, 0);
    vdd_low = 1'b0;
    run_cycle(BLANK + 1, -1, 1'b0);
    @(negedge clk); vdd_low = 1'b1;
    @(negedge clk); vdd_low = 1'b0;
    run_cycle(BLANK + 1, -1, 1'b0);
    chk("R7 uv clears warning", sw_kill, 0);
    run_cycle(BLANK + 1, -1, 1'b0);
    chk("R7 relatch after uv", sw_kill, 1);

    // R1: reset clears a latch
    do_reset();
    chk("R1 reset clears latch", sw_kill, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule